// File: doc/BRIEF.md
# CAN Acceptance Filter Group

This block is a single configurable acceptance filter group for the receive side of a CAN controller. It holds two 32-bit configuration words, a list/mask selector, a 32/16-bit scale selector and an enable. It loads all of them together on one load strobe. Together these settings turn the group into one, two or four independent sub-filters. Each sub-filter compares a packed form of the received frame's identifier fields against its configuration, either as an exact match or with a per-bit care mask.

The received frame is presented as its standard identifier, extended identifier, IDE flag and RTR flag. The block packs these fields into a 32-bit key and a 16-bit key, both left-aligned. It returns one hit bit for each sub-filter slot. A surrounding receive path ORs, prioritises and numbers the hits across many groups. The block also reports how many slots are in use and which form is selected. The hit outputs are purely combinational from the frame inputs and the registered configuration.

Top module: `can_accept_group`

## Requirements
- R1: Configuration (both words, list bit, narrow bit, active bit) is captured only on a rising clock edge with `cfg_load`=1. A synchronous `rst`=1 clears all of it to zero. Without a load, changes on the configuration inputs have no effect on any output.
- R2: Wide mask form (narrow=0, list=0) uses slot 0 only. It hits when every bit set in word B has the same value in the 32-bit key and in word A; bits clear in word B are not compared.
- R3: Wide list form (narrow=0, list=1): slot 0 hits when the 32-bit key equals word A exactly, and slot 1 when it equals word B exactly.
- R4: Narrow mask form (narrow=1, list=0): slot 0 takes its value from A[15:0] and its care mask from A[31:16]. Slot 1 does the same from word B. Each compares against the 16-bit key.
- R5: Narrow list form (narrow=1, list=1): slots 0, 1, 2, 3 hit on an exact 16-bit key match with A[15:0], A[31:16], B[15:0], B[31:16] respectively.
- R6: The 32-bit key is {std[10:0], ext[17:0], ide, rtr, 1'b0}, so a wide list entry with bit 0 set never matches.
- R7: The 16-bit key is {std[10:0], rtr, ide, ext[17:15]}.
- R8: While the loaded active bit is 0, all hit bits are 0 and `slots_used` is 0.
- R9: Hit bits at or above the number of slots in use are always 0.
- R10: `slots_used` is 1, 2, 2, 4 for the wide mask, wide list, narrow mask and narrow list forms when active. `form_list` and `form_narrow` echo the loaded list and narrow bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for the whole configuration |
| cfg_word_a | input | 32 | Configuration word A |
| cfg_word_b | input | 32 | Configuration word B |
| cfg_list | input | 1 | 1 = exact list form, 0 = mask form |
| cfg_narrow | input | 1 | 1 = 16-bit sub-filters, 0 = 32-bit sub-filters |
| cfg_active | input | 1 | Group enable |
| frm_std | input | 11 | Received standard identifier |
| frm_ext | input | 18 | Received extended identifier |
| frm_ide | input | 1 | Received IDE flag |
| frm_rtr | input | 1 | Received RTR flag |
| hit | output | 4 | One hit bit per sub-filter slot |
| slots_used | output | 3 | Number of sub-filters in use |
| form_list | output | 1 | Loaded list/mask bit |
| form_narrow | output | 1 | Loaded scale bit |

## Verification
Random configurations are paired with frames that are either fully random or built from a chosen configuration slice, so each form sees both hits and misses. Directed cases separate the forms from each other: an all-zero wide mask must pass every frame, and a care mask on the standard ID alone shows that the extended bits are ignored. Single-bit flips of exact list entries, including swapping IDE with RTR and setting the wide key's spare low bit, show that each packing keeps its own field order. A frame that matches exactly one narrow list slot shows the slot order. Further cases check an inactive group and configuration inputs changed without a load.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    localparam int STD_W    = 11;
    localparam int EXT_W    = 18;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = WORD_W / 2;
    localparam int NEXT_W   = HALF_W - STD_W - 2;
    localparam int SLOTS    = 4;
    localparam int CNT_W    = $clog2(SLOTS + 1);

    // encoding is {narrow, list}
    typedef enum logic [1:0] {
        FORM_WIDE_MASK   = 2'b00,
        FORM_WIDE_LIST   = 2'b01,
        FORM_NARROW_MASK = 2'b10,
        FORM_NARROW_LIST = 2'b11
    } form_e;

    typedef struct packed {
        logic [WORD_W-1:0] word_a;
        logic [WORD_W-1:0] word_b;
        logic              list;
        logic              narrow;
        logic              active;
    } cfg_t;

    typedef struct packed {
        logic [STD_W-1:0] std_id;
        logic [EXT_W-1:0] ext_id;
        logic             ide;
        logic             rtr;
    } frame_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic [WORD_W-1:0] care;
        logic              used;
    } lane_t;

    function automatic logic [WORD_W-1:0] pack_wide(input frame_t f);
        return {f.std_id, f.ext_id, f.ide, f.rtr, 1'b0};
    endfunction

    function automatic logic [HALF_W-1:0] pack_narrow(input frame_t f);
        return {f.std_id, f.rtr, f.ide, f.ext_id[EXT_W-1 -: NEXT_W]};
    endfunction

    function automatic form_e form_of(input cfg_t c);
        return form_e'({c.narrow, c.list});
    endfunction

    function automatic logic [CNT_W-1:0] slot_count(input form_e f);
        logic [CNT_W-1:0] n;
        case (f)
            FORM_WIDE_MASK:   n = CNT_W'(1);
            FORM_WIDE_LIST:   n = CNT_W'(2);
            FORM_NARROW_MASK: n = CNT_W'(2);
            default:          n = CNT_W'(4);
        endcase
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] widen(input logic [HALF_W-1:0] h);
        return {{HALF_W{1'b0}}, h};
    endfunction

    // Derive value, care mask and use flag of one slot from the configuration.
    function automatic lane_t build_lane(input cfg_t c, input int idx);
        lane_t             ln;
        logic [WORD_W-1:0] src;
        logic [HALF_W-1:0] half;
        ln   = '0;
        src  = (idx < 2) ? c.word_a : c.word_b;
        half = (idx % 2 == 0) ? src[HALF_W-1:0] : src[WORD_W-1:HALF_W];
        case (form_of(c))
            FORM_WIDE_MASK: begin
                if (idx == 0) begin
                    ln.value = c.word_a;
                    ln.care  = c.word_b;
                    ln.used  = 1'b1;
                end
            end
            FORM_WIDE_LIST: begin
                if (idx < 2) begin
                    ln.value = (idx == 0) ? c.word_a : c.word_b;
                    ln.care  = '1;
                    ln.used  = 1'b1;
                end
            end
            FORM_NARROW_MASK: begin
                if (idx < 2) begin
                    ln.value = widen((idx == 0) ? c.word_a[HALF_W-1:0]
                                                : c.word_b[HALF_W-1:0]);
                    ln.care  = widen((idx == 0) ? c.word_a[WORD_W-1:HALF_W]
                                                : c.word_b[WORD_W-1:HALF_W]);
                    ln.used  = 1'b1;
                end
            end
            default: begin
                ln.value = widen(half);
                ln.care  = widen({HALF_W{1'b1}});
                ln.used  = 1'b1;
            end
        endcase
        return ln;
    endfunction

endpackage

// File: rtl/can_flt_cfg.sv
module can_flt_cfg
    import can_flt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic              list,
    input  logic              narrow,
    input  logic              active,
    output cfg_t              cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q.word_a <= word_a;
            cfg_q.word_b <= word_b;
            cfg_q.list   <= list;
            cfg_q.narrow <= narrow;
            cfg_q.active <= active;
        end
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cfg_q.word_a == $past(word_a) && cfg_q.word_b == $past(word_b)
                  && cfg_q.active == $past(active))); // R1

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q)); // R1

    AST_CFG_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (cfg_q == '0)); // R1

endmodule

// File: rtl/can_flt_keypack.sv
module can_flt_keypack
    import can_flt_pkg::*;
(
    input  logic [STD_W-1:0]  std_id,
    input  logic [EXT_W-1:0]  ext_id,
    input  logic              ide,
    input  logic              rtr,
    output logic [WORD_W-1:0] key_wide,
    output logic [HALF_W-1:0] key_narrow
);

    frame_t frm;

    always_comb begin
        frm.std_id = std_id;
        frm.ext_id = ext_id;
        frm.ide    = ide;
        frm.rtr    = rtr;
        key_wide   = pack_wide(frm);
        key_narrow = pack_narrow(frm);
    end

    always_comb begin
        assert (key_wide[0] == 1'b0); // R6
    end

endmodule

// File: rtl/can_flt_lane.sv
module can_flt_lane
    import can_flt_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic [WORD_W-1:0] key_wide,
    input  logic [HALF_W-1:0] key_narrow,
    output logic              hit,
    output logic              used
);

    lane_t             ln;
    logic [WORD_W-1:0] key;
    logic [WORD_W-1:0] diff;

    always_comb begin
        ln   = build_lane(cfg, IDX);
        key  = cfg.narrow ? widen(key_narrow) : key_wide;
        diff = (key ^ ln.value) & ln.care;
        used = ln.used;
        hit  = cfg.active & ln.used & ~|diff;
    end

    AST_LANE_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !used |-> !hit); // R9

    AST_LANE_NO_CARE_PASS: assert property (@(posedge clk) disable iff (rst)
        (cfg.active && used && !cfg.narrow && !cfg.list && cfg.word_b == '0) |-> hit); // R2

endmodule

// File: rtl/can_accept_group.sv
module can_accept_group
    import can_flt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [31:0]       cfg_word_a,
    input  logic [31:0]       cfg_word_b,
    input  logic              cfg_list,
    input  logic              cfg_narrow,
    input  logic              cfg_active,
    input  logic [10:0]       frm_std,
    input  logic [17:0]       frm_ext,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    output logic [3:0]        hit,
    output logic [2:0]        slots_used,
    output logic              form_list,
    output logic              form_narrow
);

    cfg_t              cfg_q;
    logic [WORD_W-1:0] key_wide;
    logic [HALF_W-1:0] key_narrow;
    logic [SLOTS-1:0]  lane_hit;
    logic [SLOTS-1:0]  lane_used;

    can_flt_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_load),
        .word_a (cfg_word_a),
        .word_b (cfg_word_b),
        .list   (cfg_list),
        .narrow (cfg_narrow),
        .active (cfg_active),
        .cfg_q  (cfg_q)
    );

    can_flt_keypack u_keys (
        .std_id     (frm_std),
        .ext_id     (frm_ext),
        .ide        (frm_ide),
        .rtr        (frm_rtr),
        .key_wide   (key_wide),
        .key_narrow (key_narrow)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_lane
        can_flt_lane #(.IDX(i)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg_q),
            .key_wide   (key_wide),
            .key_narrow (key_narrow),
            .hit        (lane_hit[i]),
            .used       (lane_used[i])
        );
    end

    always_comb begin
        hit         = lane_hit;
        slots_used  = cfg_q.active ? slot_count(form_of(cfg_q)) : '0;
        form_list   = cfg_q.list;
        form_narrow = cfg_q.narrow;
    end

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.active |-> (hit == '0 && slots_used == '0)); // R8

    AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (hit >> slots_used) == '0); // R9

    AST_SLOT_COUNT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ($countones(slots_used) <= 1 && slots_used <= 3'd4)); // R10

    AST_USED_MATCHES_COUNT: assert property (@(posedge clk) disable iff (rst)
        cfg_q.active |-> ($countones(lane_used) == int'(slots_used))); // R10

endmodule

// File: tb/can_accept_group_bench.sv
module can_accept_group_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_load;
    logic [31:0] cfg_word_a, cfg_word_b;
    logic        cfg_list, cfg_narrow, cfg_active;
    logic [10:0] frm_std;
    logic [17:0] frm_ext;
    logic        frm_ide, frm_rtr;
    logic [3:0]  hit;
    logic [2:0]  slots_used;
    logic        form_list, form_narrow;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // bench-side copy of what has been loaded
    logic [31:0] m_a, m_b;
    logic        m_list, m_narrow, m_act;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_accept_group u_can_accept_group (
        .clk(clk), .rst(rst), .cfg_load(cfg_load),
        .cfg_word_a(cfg_word_a), .cfg_word_b(cfg_word_b),
        .cfg_list(cfg_list), .cfg_narrow(cfg_narrow), .cfg_active(cfg_active),
        .frm_std(frm_std), .frm_ext(frm_ext), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
        .hit(hit), .slots_used(slots_used),
        .form_list(form_list), .form_narrow(form_narrow)
    );

    function automatic logic [31:0] k32(logic [10:0] s, logic [17:0] e, logic i, logic r);
        return {s, e, i, r, 1'b0};
    endfunction

    function automatic logic [15:0] k16(logic [10:0] s, logic [17:0] e, logic i, logic r);
        return {s, r, i, e[17:15]};
    endfunction

    function automatic logic [3:0] exp_hit();
        logic [31:0] kw;
        logic [15:0] kn;
        logic [3:0]  h;
        kw = k32(frm_std, frm_ext, frm_ide, frm_rtr);
        kn = k16(frm_std, frm_ext, frm_ide, frm_rtr);
        h  = 4'b0;
        if (m_act) begin
            case ({m_narrow, m_list})
                2'b00: h[0] = ((kw ^ m_a) & m_b) == 32'd0;
                2'b01: begin h[0] = (kw == m_a); h[1] = (kw == m_b); end
                2'b10: begin
                    h[0] = ((kn ^ m_a[15:0]) & m_a[31:16]) == 16'd0;
                    h[1] = ((kn ^ m_b[15:0]) & m_b[31:16]) == 16'd0;
                end
                default: begin
                    h[0] = (kn == m_a[15:0]);  h[1] = (kn == m_a[31:16]);
                    h[2] = (kn == m_b[15:0]);  h[3] = (kn == m_b[31:16]);
                end
            endcase
        end
        return h;
    endfunction

    function automatic logic [2:0] exp_slots();
        if (!m_act) return 3'd0;
        case ({m_narrow, m_list})
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic string form_tag();
        if (!m_act) return "R8";
        case ({m_narrow, m_list})
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_hit(string tag, logic [3:0] expv);
        checks++;
        if (hit !== expv) begin
            failures++;
            $display("FAIL %s hit actual=%b expected=%b", tag, hit, expv);
        end
    endtask

    task automatic check_all(string tag);
        check_hit(tag, exp_hit());
        checks++;
        if (slots_used !== exp_slots() || form_list !== m_list || form_narrow !== m_narrow) begin
            failures++;
            $display("FAIL %s R10 slots/form actual=%0d/%b/%b expected=%0d/%b/%b", tag,
                     slots_used, form_list, form_narrow, exp_slots(), m_list, m_narrow);
        end
    endtask

    task automatic load_cfg(logic [31:0] a, logic [31:0] b, logic l, logic n, logic act);
        @(negedge clk);
        cfg_word_a = a; cfg_word_b = b; cfg_list = l; cfg_narrow = n; cfg_active = act;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        m_a = a; m_b = b; m_list = l; m_narrow = n; m_act = act;
    endtask

    task automatic set_frame(logic [10:0] s, logic [17:0] e, logic i, logic r);
        frm_std = s; frm_ext = e; frm_ide = i; frm_rtr = r;
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] r;
        logic [31:0] a, b;
        logic [15:0] h;
        void'($urandom(32'd20231));
        rst = 1'b1; cfg_load = 1'b0;
        cfg_word_a = '0; cfg_word_b = '0; cfg_list = 0; cfg_narrow = 0; cfg_active = 0;
        m_a = '0; m_b = '0; m_list = 0; m_narrow = 0; m_act = 0;
        set_frame(11'h0, 18'h0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state: zero config means inactive, no hits
        check_all("R1");

        // R2 all-zero wide mask passes everything, slot 0 only (R9)
        load_cfg(32'h0, 32'h0, 1'b0, 1'b0, 1'b1);
        set_frame(11'h3C1, 18'h2F0F0, 1'b1, 1'b1);
        check_hit("R2", 4'b0001);
        set_frame(11'h000, 18'h00001, 1'b0, 1'b0);
        check_hit("R9", 4'b0001);
        check_all("R10");

        // R2 care only std id bits
        load_cfg(k32(11'h5A5, 18'h0, 1'b0, 1'b0), {11'h7FF, 21'h0}, 1'b0, 1'b0, 1'b1);
        set_frame(11'h5A5, 18'h3FFFF, 1'b1, 1'b0);
        check_hit("R2", 4'b0001);
        set_frame(11'h5A4, 18'h0, 1'b0, 1'b0);
        check_hit("R2", 4'b0000);

        // R3 / R6 wide list exact matches and field order
        load_cfg(k32(11'h123, 18'h2ABCD, 1'b1, 1'b0), k32(11'h7FE, 18'h00011, 1'b0, 1'b1),
                 1'b1, 1'b0, 1'b1);
        set_frame(11'h123, 18'h2ABCD, 1'b1, 1'b0);
        check_hit("R3", 4'b0001);
        set_frame(11'h7FE, 18'h00011, 1'b0, 1'b1);
        check_hit("R3", 4'b0010);
        set_frame(11'h123, 18'h2ABCD, 1'b0, 1'b1);
        check_hit("R6", 4'b0000);
        set_frame(11'h123, 18'h2ABCC, 1'b1, 1'b0);
        check_hit("R3", 4'b0000);
        load_cfg(k32(11'h123, 18'h2ABCD, 1'b1, 1'b0) | 32'h1, 32'h0, 1'b1, 1'b0, 1'b1);
        set_frame(11'h123, 18'h2ABCD, 1'b1, 1'b0);
        check_hit("R6", 4'b0000);

        // R5 / R7 narrow list: each slot alone
        load_cfg({k16(11'h011, 18'h08000, 1'b0, 1'b1), k16(11'h010, 18'h00000, 1'b0, 1'b0)},
                 {k16(11'h013, 18'h38000, 1'b1, 1'b1), k16(11'h012, 18'h10000, 1'b1, 1'b0)},
                 1'b1, 1'b1, 1'b1);
        set_frame(11'h010, 18'h00000, 1'b0, 1'b0);
        check_hit("R5", 4'b0001);
        set_frame(11'h011, 18'h08000, 1'b0, 1'b1);
        check_hit("R5", 4'b0010);
        set_frame(11'h012, 18'h10000, 1'b1, 1'b0);
        check_hit("R5", 4'b0100);
        set_frame(11'h013, 18'h38000, 1'b1, 1'b1);
        check_hit("R5", 4'b1000);
        set_frame(11'h011, 18'h08000, 1'b1, 1'b0);
        check_hit("R7", 4'b0000);
        set_frame(11'h010, 18'h07FFF, 1'b0, 1'b0);
        check_hit("R7", 4'b0001);
        check_all("R10");

        // R4 narrow mask: care on std only in slot 0, full care in slot 1
        load_cfg({16'hFFE0, k16(11'h2AA, 18'h0, 1'b0, 1'b0)},
                 {16'hFFFF, k16(11'h155, 18'h20000, 1'b1, 1'b0)}, 1'b0, 1'b1, 1'b1);
        set_frame(11'h2AA, 18'h3FFFF, 1'b1, 1'b1);
        check_hit("R4", 4'b0001);
        set_frame(11'h155, 18'h20000, 1'b1, 1'b0);
        check_hit("R4", 4'b0010);
        set_frame(11'h155, 18'h00000, 1'b1, 1'b0);
        check_hit("R4", 4'b0000);

        // R8 inactive group with a matching entry
        load_cfg(32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        set_frame(11'h001, 18'h1, 1'b0, 1'b0);
        check_hit("R8", 4'b0000);
        check_all("R8");

        // R1 no load: new config inputs are ignored
        load_cfg(32'h0, 32'h0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        cfg_word_a = 32'h0; cfg_word_b = 32'hFFFF_FFFF; cfg_list = 0; cfg_narrow = 0;
        cfg_active = 0;
        repeat (2) @(negedge clk);
        set_frame(11'h0, 18'h0, 1'b0, 1'b0);
        check_hit("R1", 4'b1111);
        check_all("R1");

        // random mix
        for (int it = 0; it < 1500; it++) begin
            if (it % 4 == 0) begin
                a = $urandom(); b = $urandom();
                r = $urandom();
                if (r[3:2] == 2'b00) b = b & $urandom() & $urandom();
                load_cfg(a, b, r[0], r[1], r[7:4] != 4'h0);
            end
            r = $urandom();
            frm_std = r[10:0]; frm_ext = {r[28:11]}; frm_ide = r[29]; frm_rtr = r[30];
            if (r[31]) begin
                r = $urandom();
                if (!m_narrow) begin
                    a = r[0] ? m_a : m_b;
                    frm_std = a[31:21]; frm_ext = a[20:3]; frm_ide = a[2]; frm_rtr = a[1];
                end else begin
                    a = r[1] ? m_a : m_b;
                    h = r[0] ? a[31:16] : a[15:0];
                    frm_std = h[15:5]; frm_rtr = h[4]; frm_ide = h[3];
                    frm_ext[17:15] = h[2:0];
                end
            end
            #1;
            check_all(form_tag());
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule